// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory port. A new base address is captured from the address input whenever one of two active-low address strobes is accepted. The processor strobe counts only while chip enable is asserted low. The controller strobe counts regardless of chip enable. After a capture, a 2-bit burst counter starts from zero. While no strobe is accepted, the advance input decides whether the counter steps or holds.

The output address keeps the upper bits exactly as captured. Its two lowest bits are built from the captured base bits and the counter, in one of two orders picked by a static select input. In interleaved order the low bits are the base XOR the count. In linear order they are the base plus the count, modulo four. Four steps bring the counter back to zero, so the burst returns to its base word and keeps cycling while advance stays low. The output comes straight from the registers, so a captured or stepped address is visible right after the clock edge that produced it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it is released, addr_out is all zeros and the burst count is zero.
- R2: When ctl_strobe_n is low at a rising edge, addr_in is captured and the count is cleared, whatever the value of chip_en_n; addr_out then equals the captured addr_in.
- R3: When cpu_strobe_n is low and chip_en_n is low at a rising edge, addr_in is captured and the count is cleared. When chip_en_n is high, cpu_strobe_n has no effect, and advance alone decides the next address.
- R4: If no strobe is accepted and adv_n is low at a rising edge, the burst count increases by one.
- R5: If no strobe is accepted and adv_n is high at a rising edge, addr_out keeps its value.
- R6: With order_ilv high, addr_out[1:0] equals the base low bits XOR the count. From base 01 the sequence is 01, 00, 11, 10; from base 10 it is 10, 11, 00, 01.
- R7: With order_ilv low, addr_out[1:0] equals the base low bits plus the count, modulo 4. From base 01 the sequence is 01, 10, 11, 00; from base 11 it is 11, 00, 01, 10.
- R8: After the fourth beat, the next advance returns addr_out to the base address, and the burst keeps cycling.
- R9: addr_out[AW-1:2] always equals the upper bits of the last captured address.
- R10: An accepted strobe takes priority over a low adv_n in the same cycle. It reloads the base and restarts the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | AW | External base address |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, qualified by chip_en_n |
| ctl_strobe_n | input | 1 | Controller address strobe, active low, not qualified |
| chip_en_n | input | 1 | Active-low chip enable that gates the processor strobe |
| adv_n | input | 1 | Active-low burst advance |
| order_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear; static |
| addr_out | output | AW | Current burst word address |

## Verification
The assertions assume that order_ilv stays fixed while the block runs. The interleaved and linear stepping checks compare each address with the one before it, and that comparison only means something if the order did not change in between. The stimulus changes the order only across a reset, and every burst in the bench starts with a strobe. The assertions also assume that all control inputs hold known values at every sampled edge, and the bench drives every input from the first cycle onward.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cpu_strobe_n,
  input  logic          ctl_strobe_n,
  input  logic          chip_en_n,
  input  logic          adv_n,
  input  logic          order_ilv,
  output logic [AW-1:0] addr_out
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          load;
  logic [1:0]    low_ilv;
  logic [1:0]    low_lin;

  assign load = ~ctl_strobe_n | (~cpu_strobe_n & ~chip_en_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= 2'd0;
    end else if (!adv_n) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign low_ilv  = base_q[1:0] ^ cnt_q;
  assign low_lin  = base_q[1:0] + cnt_q;
  assign addr_out = {base_q[AW-1:2], order_ilv ? low_ilv : low_lin};

endmodule

module burst_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          cpu_strobe_n,
  input logic          ctl_strobe_n,
  input logic          chip_en_n,
  input logic          adv_n,
  input logic          order_ilv,
  input logic [AW-1:0] addr_out
);

  logic acc;
  assign acc = ~ctl_strobe_n | (~cpu_strobe_n & ~chip_en_n);

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> addr_out == '0);

  a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_strobe_n |=> addr_out == $past(addr_in));

  a_r3_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !chip_en_n) |=> addr_out == $past(addr_in));

  a_r3_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && chip_en_n && ctl_strobe_n && adv_n) |=> $stable(addr_out));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && adv_n) |=> $stable(addr_out));

  a_r6_ilv_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !adv_n && order_ilv) |=> addr_out[0] != $past(addr_out[0]));

  a_r7_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !adv_n && !order_ilv) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));

  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !adv_n) |=> addr_out == $past(addr_in));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 16;
  localparam int NV = 27;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          cpu_strobe_n, ctl_strobe_n, chip_en_n, adv_n, order_ilv;
  logic [AW-1:0] addr_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .chip_en_n(chip_en_n), .adv_n(adv_n), .order_ilv(order_ilv),
    .addr_out(addr_out)
  );

  // {req[4], ctl_n, cpu_n, ce_n, adv_n, ilv, addr_in[16], expect[16]}
  localparam logic [40:0] VEC [NV] = '{
    {4'd2,  1'b0,1'b1,1'b1,1'b1,1'b1, 16'hA5C1, 16'hA5C1}, // R2 load, ce high
    {4'd6,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'hA5C0}, // R6
    {4'd6,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'hA5C3}, // R6
    {4'd6,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'hA5C2}, // R6
    {4'd8,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'hA5C1}, // R8 wrap
    {4'd5,  1'b1,1'b1,1'b0,1'b1,1'b1, 16'h1111, 16'hA5C1}, // R5 hold
    {4'd8,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'hA5C0}, // R8 keeps cycling
    {4'd3,  1'b1,1'b0,1'b0,1'b1,1'b1, 16'h1232, 16'h1232}, // R3 cpu load
    {4'd6,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'h1233}, // R6
    {4'd6,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'h1230}, // R6
    {4'd9,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'hFFFF, 16'h1231}, // R9 upper kept
    {4'd3,  1'b1,1'b0,1'b1,1'b1,1'b1, 16'hFFFF, 16'h1231}, // R3 gated, hold
    {4'd4,  1'b1,1'b0,1'b1,1'b0,1'b1, 16'hFFFF, 16'h1232}, // R4 gated, step
    {4'd2,  1'b0,1'b1,1'b1,1'b1,1'b1, 16'h0F0E, 16'h0F0E}, // R2 ce ignored
    {4'd10, 1'b0,1'b1,1'b0,1'b0,1'b1, 16'h7777, 16'h7777}, // R10 priority
    {4'd4,  1'b1,1'b1,1'b0,1'b0,1'b1, 16'h0000, 16'h7776}, // R4
    {4'd2,  1'b0,1'b1,1'b0,1'b1,1'b0, 16'h4441, 16'h4441}, // R2 linear phase
    {4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'h4442}, // R7
    {4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'h4443}, // R7
    {4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'h4440}, // R7
    {4'd8,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'h4441}, // R8 wrap
    {4'd3,  1'b1,1'b0,1'b0,1'b0,1'b0, 16'hBEE3, 16'hBEE3}, // R3 load beats adv
    {4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'hBEE0}, // R7
    {4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'hBEE1}, // R7
    {4'd5,  1'b1,1'b1,1'b0,1'b1,1'b0, 16'h0000, 16'hBEE1}, // R5
    {4'd7,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'hBEE2}, // R7
    {4'd8,  1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'hBEE3}  // R8
  };

  function automatic string tag(input int k);
    case (k)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr_out !== exp) begin
      bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic idle();
    ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; chip_en_n = 1'b1; adv_n = 1'b1;
    addr_in = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1", '0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    check("R1", '0);
  endtask

  initial begin
    rst_n = 1'b0;
    order_ilv = 1'b1;
    idle();
    do_reset();
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32] != order_ilv) begin
        order_ilv = VEC[i][32];
        do_reset();
      end
      ctl_strobe_n = VEC[i][36];
      cpu_strobe_n = VEC[i][35];
      chip_en_n    = VEC[i][34];
      adv_n        = VEC[i][33];
      addr_in      = VEC[i][31:16];
      @(posedge clk); #2;
      check(tag(int'(VEC[i][40:37])), VEC[i][15:0]);
    end
    // R1: reset in the middle of a burst, then advance from zero
    adv_n = 1'b0;
    @(posedge clk); #2;
    do_reset();
    adv_n = 1'b0;
    @(posedge clk); #2;
    check("R1", 16'h0001);
    idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule